// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This block takes a snapshot of a free-running 16-bit timer when a chosen event occurs on an external pin. It first passes the pin through a two-flop synchronizer. It then finds rising and falling edges on the synchronized signal, and a small edge counter thins the rising edges to one in four or one in sixteen when those ratios are selected. When a qualifying event fires, the whole timer word is written into the capture register in one clock. A sticky flag is raised at the same time, and software clears it with a one-cycle strobe.

A 4-bit mode word picks the behaviour. Codes `0100` to `0111` are the capture modes: falling edge, rising edge, every 4th rising edge and every 16th rising edge. Every other code, including the idle code `0000`, leaves the capture register and the flag unchanged and holds the edge counter at zero. Moving directly from one capture code to another does not reset the edge counter. After such a move, the first capture can therefore land after fewer edges than the new ratio.

Top module: `tmr_capture_unit`

## Requirements
- R1: On a capture, `capVal` takes the value that `timerVal` held just before the clock edge on which the capture happens. That edge is the third rising clock edge after the pin change is set up: two synchronizer stages, then the capture edge.
- R2: With mode `0100`, a capture happens on every falling edge of the synchronized pin and on no rising edge.
- R3: With mode `0101`, a capture happens on every rising edge of the synchronized pin and on no falling edge.
- R4: With mode `0110`, rising edges are counted and a capture happens when the count, taken modulo 16, becomes a multiple of 4.
- R5: With mode `0111`, rising edges are counted and a capture happens when the count, taken modulo 16, returns to 0, which is every 16th rising edge counted from zero.
- R6: Every capture sets `capFlag`. The flag stays set until `flagClr` is sampled high, and it does not change on any other cycle.
- R7: `flagClr` high clears the flag on the next edge. If a capture happens on the same edge, the flag stays set.
- R8: A new capture overwrites `capVal` whether or not the previous value was read.
- R9: While the mode is not one of `0100` to `0111`, `capVal` and `capFlag` never change from a capture, and the rising-edge count is held at zero.
- R10: Changing directly from one capture mode to another keeps the rising-edge count. Mode `0111` with 3 counted edges followed by mode `0110` captures on the very next rising edge.
- R11: After reset, `capVal` is 0, `capFlag` is 0 and the edge count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Current value of the free-running timer |
| pinIn | input | 1 | Asynchronous event pin |
| modeSel | input | 4 | Mode code (`0100`..`0111` capture; others idle) |
| flagClr | input | 1 | One-cycle strobe that clears the flag |
| capVal | output | 16 | Capture register |
| capFlag | output | 1 | Sticky capture flag |

## Verification
A corrupted edge counter does not show at the ports at once. It appears at the next capture in a prescaled mode, which lands one or more rising edges early or late and so carries a timer value off by whole edge periods. A stuck synchronizer or edge-history flop shows within three clocks of a pin change: either a missing capture, or a capture in the wrong polarity mode. A wrong flag state shows on the first clear strobe, or on the first capture after one. The bench sweeps all sixteen mode codes with twenty pulses each, so every one of these faults reaches a port.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [3:0] {
    MODE_OFF    = 4'b0000,
    MODE_FALL   = 4'b0100,
    MODE_RISE   = 4'b0101,
    MODE_RISE4  = 4'b0110,
    MODE_RISE16 = 4'b0111
  } capMode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic capLoad;
    logic flagSet;
  } capStrobe_t;

  function automatic logic isCapMode(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

endpackage

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_LO    = 4,
  parameter int RATIO_HI    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [3:0] modeSel,
  output capStrobe_t strobe
);

  localparam int CNT_W = $clog2(RATIO_HI);
  localparam int LO_W  = $clog2(RATIO_LO);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic                   pinPrev;
  logic                   riseEdge;
  logic                   fallEdge;
  logic [CNT_W-1:0]       edgeCnt;
  logic                   capMode;
  logic                   loWrap;
  logic                   hiWrap;
  logic                   capEvent;

  // synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], pinIn};
      pinPrev <= pinSync;
    end
  end

  assign pinSync  = syncQ[SYNC_STAGES-1];
  assign riseEdge = pinSync & ~pinPrev;
  assign fallEdge = ~pinSync & pinPrev;
  assign capMode  = isCapMode(modeSel);

  // rising-edge counter: kept across capture modes, cleared otherwise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (!capMode) begin
      edgeCnt <= '0;
    end else if (riseEdge) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign loWrap = &edgeCnt[LO_W-1:0];
  assign hiWrap = &edgeCnt;

  always_comb begin
    capEvent = 1'b0;
    case (modeSel)
      MODE_FALL:   capEvent = fallEdge;
      MODE_RISE:   capEvent = riseEdge;
      MODE_RISE4:  capEvent = riseEdge & loWrap;
      MODE_RISE16: capEvent = riseEdge & hiWrap;
      default:     capEvent = 1'b0;
    endcase
  end

  assign strobe.capLoad = capEvent;
  assign strobe.flagSet = capEvent;

endmodule

// File: rtl/tcap_dpath.sv
module tcap_dpath
  import tcap_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] timerVal,
  input  capStrobe_t       strobe,
  input  logic             flagClr,
  output logic [TMR_W-1:0] capVal,
  output logic             capFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capVal <= '0;
    end else if (strobe.capLoad) begin
      capVal <= timerVal;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFlag <= 1'b0;
    end else if (strobe.flagSet) begin
      capFlag <= 1'b1;
    end else if (flagClr) begin
      capFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMR_W-1:0] timerVal,
  input  logic             pinIn,
  input  logic [3:0]       modeSel,
  input  logic             flagClr,
  output logic [TMR_W-1:0] capVal,
  output logic             capFlag
);

  capStrobe_t strobe;

  tcap_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .RATIO_LO   (4),
    .RATIO_HI   (16)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .modeSel(modeSel),
    .strobe (strobe)
  );

  tcap_dpath #(
    .TMR_W(TMR_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .timerVal(timerVal),
    .strobe  (strobe),
    .flagClr (flagClr),
    .capVal  (capVal),
    .capFlag (capFlag)
  );

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [TMR_W-1:0] timerVal,
  input logic [3:0]       modeSel,
  input logic             flagClr,
  input logic [TMR_W-1:0] capVal,
  input logic             capFlag
);

  // R1: a changed capture register holds the previous timer value
  a_r1_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capVal) |-> capVal == $past(timerVal));

  // R6: a new capture value comes with the flag set
  a_r6_flag_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capVal) |-> capFlag);

  // R6: without a clear the flag stays set
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);

  // R7: the flag only drops after a clear strobe
  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(capFlag) |-> $past(flagClr));

  // R9: idle and non-capture codes never capture
  a_r9_idle_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[3:2] != 2'b01) |=> ($stable(capVal) && !$rose(capFlag)));

endmodule

bind tmr_capture_unit tcap_checker #(.TMR_W(TMR_W)) u_tcap_checker (
  .clk     (clk),
  .rstN    (rstN),
  .timerVal(timerVal),
  .modeSel (modeSel),
  .flagClr (flagClr),
  .capVal  (capVal),
  .capFlag (capFlag)
);

// File: tb/tmr_capture_unit_bench.sv
module tmr_capture_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] timerVal;
  logic        pinIn;
  logic [3:0]  modeSel;
  logic        flagClr;
  logic [15:0] capVal;
  logic        capFlag;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  logic [15:0] expCap;
  logic        expFlag;
  int          rc;

  always #5 clk = ~clk;

  tmr_capture_unit u_tmr_capture_unit (
    .clk     (clk),
    .rstN    (rstN),
    .timerVal(timerVal),
    .pinIn   (pinIn),
    .modeSel (modeSel),
    .flagClr (flagClr),
    .capVal  (capVal),
    .capFlag (capFlag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [3:0] m);
    case (m)
      4'b0100: return "R2";
      4'b0101: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic setMode(input logic [3:0] m);
    @(negedge clk);
    modeSel  = m;
    timerVal = timerVal + 16'd13;
    @(negedge clk);
    timerVal = timerVal + 16'd13;
    if (m[3:2] != 2'b01) rc = 0;
  endtask

  task automatic pulseClr();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    expFlag = 1'b0;
    chk("R7", {15'd0, capFlag}, {15'd0, expFlag});
  endtask

  // change the pin, wait through the synchronizer and the capture edge, then check
  task automatic drivePin(input logic v, input bit clrAtCap);
    logic        prevV;
    logic        isRise;
    logic        isFall;
    logic        capNow;
    logic [15:0] tvCap;
    prevV  = pinIn;
    isRise = v & ~prevV;
    isFall = ~v & prevV;
    @(negedge clk);
    pinIn    = v;
    timerVal = timerVal + 16'd13;
    @(negedge clk);
    timerVal = timerVal + 16'd13;
    @(negedge clk);
    timerVal = timerVal + 16'd13;
    tvCap    = timerVal;
    if (clrAtCap) flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    capNow  = 1'b0;
    if (modeSel[3:2] == 2'b01) begin
      if (isRise) rc = (rc + 1) % 16;
      case (modeSel)
        4'b0100: capNow = isFall;
        4'b0101: capNow = isRise;
        4'b0110: capNow = isRise && (rc % 4 == 0);
        4'b0111: capNow = isRise && (rc == 0);
        default: capNow = 1'b0;
      endcase
    end
    if (capNow) begin
      expCap  = tvCap;
      expFlag = 1'b1;
    end else if (clrAtCap) begin
      expFlag = 1'b0;
    end
    chk(capNow ? "R1" : modeTag(modeSel), capVal, expCap);
    chk("R6", {15'd0, capFlag}, {15'd0, expFlag});
    timerVal = timerVal + 16'd13;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] firstCap;
    rstN     = 1'b0;
    pinIn    = 1'b0;
    modeSel  = 4'b0000;
    flagClr  = 1'b0;
    timerVal = 16'h1234;
    expCap   = 16'd0;
    expFlag  = 1'b0;
    rc       = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", capVal, 16'd0);
    chk("R11", {15'd0, capFlag}, 16'd0);

    // every mode code, twenty pulses each
    for (int m = 0; m < 16; m++) begin
      setMode(4'b0000);
      setMode(m[3:0]);
      pulseClr();
      for (int i = 0; i < 20; i++) begin
        drivePin(1'b1, 1'b0);
        drivePin(1'b0, 1'b0);
      end
    end

    // R8: overwrite without reading
    setMode(4'b0000);
    setMode(4'b0101);
    drivePin(1'b1, 1'b0);
    firstCap = capVal;
    drivePin(1'b0, 1'b0);
    drivePin(1'b1, 1'b0);
    chk("R8", capVal, expCap);
    chk("R8", {15'd0, capVal != firstCap}, 16'd1);

    // R7: capture and clear on the same edge, capture wins
    pulseClr();
    drivePin(1'b0, 1'b0);
    drivePin(1'b1, 1'b1);
    chk("R7", {15'd0, capFlag}, 16'd1);
    drivePin(1'b0, 1'b1);
    chk("R7", {15'd0, capFlag}, 16'd0);

    // R10: direct switch keeps a stale count
    setMode(4'b0000);
    setMode(4'b0111);
    for (int i = 0; i < 3; i++) begin
      drivePin(1'b1, 1'b0);
      drivePin(1'b0, 1'b0);
    end
    pulseClr();
    setMode(4'b0110);
    drivePin(1'b1, 1'b0);
    chk("R10", {15'd0, capFlag}, 16'd1);
    chk("R10", capVal, expCap);
    drivePin(1'b0, 1'b0);

    // R9: passing through idle clears the count, so four edges are needed
    setMode(4'b0000);
    setMode(4'b0110);
    pulseClr();
    for (int i = 0; i < 3; i++) begin
      drivePin(1'b1, 1'b0);
      drivePin(1'b0, 1'b0);
    end
    chk("R9", {15'd0, capFlag}, 16'd0);
    drivePin(1'b1, 1'b0);
    chk("R9", {15'd0, capFlag}, 16'd1);
    drivePin(1'b0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule